// File: doc/BRIEF.md
# Dual-Mode Output Sample Buffer

This block is an eight-entry store that sits between a sample producer and a processor that reads results. It has two behaviours, chosen by one mode input.

In queue mode it keeps every valid sample in arrival order. It reports its fill level, and it raises a ready flag and a one-cycle interrupt once the fill level climbs to a programmable threshold. In capture mode it counts valid samples and, once every programmed interval, records a short burst of consecutive samples into the store. The store is refilled from its first entry on every burst.

The processor walks through stored samples with an advance strobe. It can clear the store at any time with a reset command strobe.

The control is a three-state machine:
- FIFO_RUN is the queue-mode state.
- SNAP_ARMED waits for an interval timeout.
- SNAP_BURST collects the rest of a burst.

The transitions are:
- A reset command or a mode change goes to FIFO_RUN when the mode input is 1, and to SNAP_ARMED when it is 0.
- SNAP_ARMED goes to SNAP_BURST on a timeout when the burst length is above one. With a burst length of one it stays in SNAP_ARMED.
- SNAP_BURST returns to SNAP_ARMED on the sample that completes the burst.

Top module: `dual_mode_sample_buf`

## Requirements
- R1: After reset, fill_depth is 0 and ready, irq and overflow are 0. The read pointer is 7 and the write pointer is 0, so the first sample written is visible on rd_data at once.
- R2: rd_data shows the entry one past the read pointer. An rd_advance with fill_depth above 0 moves to the next entry and lowers fill_depth by one. An rd_advance at fill_depth 0 has no effect.
- R3: In queue mode (mode_fifo = 1), each in_valid stores in_data and raises fill_depth by one. A write and an advance in the same cycle leave fill_depth unchanged. fill_depth never exceeds 8.
- R4: In queue mode, a write at fill_depth 8 is dropped and sets overflow. overflow stays set until a reset command or a mode change.
- R5: irq is high for exactly one cycle, the cycle after an accepted write (with no advance in the same cycle) raises fill_depth to the effective threshold. The effective threshold is fifo_thresh, or 1 when fifo_thresh is 0.
- R6: ready is high when in queue mode and fill_depth is at or above the effective threshold. ready is always low in capture mode.
- R7: A ptr_reset pulse empties the store and sets the read pointer to 7 and the write pointer to 0. It clears overflow, irq and the interval and burst counters.
- R8: A change of mode_fifo clears the store, the pointers, overflow and both counters on the next edge. In_valid and rd_advance are ignored in that cycle.
- R9: In capture mode (mode_fifo = 0), the interval counter advances only on in_valid. A timeout occurs on every (snap_interval + 1)-th valid sample. The counter keeps running during bursts.
- R10: A timeout outside a burst starts a burst. The burst stores the timeout sample and the following valid samples into entries 0 upward, with the read pointer set back to 7 and fill_depth restarting at 1. Timeouts during a burst are ignored.
- R11: The burst length is snap_count, taken as 1 when snap_count is 0 and as 8 when snap_count is above 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_fifo | input | 1 | 1 selects queue mode, 0 selects capture mode |
| fifo_thresh | input | 3 | Queue-mode fill threshold (0 acts as 1) |
| snap_interval | input | 8 | Capture interval minus one, counted in valid samples |
| snap_count | input | 4 | Burst length (0 acts as 1, above 8 acts as 8) |
| ptr_reset | input | 1 | Reset-command strobe |
| rd_advance | input | 1 | Advance-read strobe |
| in_valid | input | 1 | Incoming sample is valid |
| in_data | input | 16 | Incoming sample |
| rd_data | output | 16 | Entry after the read pointer |
| fill_depth | output | 4 | Number of unread entries |
| ready | output | 1 | Fill level at or above threshold (queue mode) |
| irq | output | 1 | One-cycle threshold-crossing pulse |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with its default parameters: 16-bit samples, eight entries, an 8-bit interval and a 4-bit burst field.

Eight entries let a few writes reach the full and overflow cases. The 4-bit burst field can carry values above eight, which exercises the clamp.

Small programmed intervals make several timeouts fit in a short run. Some of those timeouts land inside a burst, where they must be ignored. Idle cycles between valid samples show that only valid samples move the interval count.

// File: rtl/dmsb_pkg.sv
package dmsb_pkg;

    typedef enum logic [1:0] {
        ST_FIFO_RUN   = 2'd0,
        ST_SNAP_ARMED = 2'd1,
        ST_SNAP_BURST = 2'd2
    } dmsb_state_e;

endpackage

// File: rtl/dmsb_store.sv
module dmsb_store #(
    parameter int DATA_W = 16,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[g] <= '0;
            else if (we && (waddr == AW'(g)))
                cells[g] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dmsb_ctrl.sv
module dmsb_ctrl
    import dmsb_pkg::*;
#(
    parameter int AW    = 3,
    parameter int IVL_W = 8,
    parameter int BL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_fifo,
    input  logic             ptr_reset,
    input  logic             in_valid,
    input  logic [IVL_W-1:0] interval,
    input  logic [BL_W-1:0]  burst_len,
    output logic             clear_o,
    output logic             wr_req_o,
    output logic             snap_start_o,
    output logic             fifo_active_o
);
    localparam int DEPTH = 1 << AW;
    localparam int BCW   = AW + 1;

    dmsb_state_e      state_q, state_d;
    logic             mode_q;
    logic [IVL_W-1:0] ivl_q, ivl_d;
    logic [BCW-1:0]   burst_q, burst_d;
    logic [BCW-1:0]   n_eff;
    logic             timeout;

    // burst length clamp: 0 -> 1, above DEPTH -> DEPTH
    always_comb begin
        if (burst_len == '0)
            n_eff = BCW'(1);
        else if (int'(burst_len) > DEPTH)
            n_eff = BCW'(DEPTH);
        else
            n_eff = BCW'(burst_len);
    end

    assign clear_o = ptr_reset | (mode_fifo != mode_q);
    assign timeout = in_valid && (ivl_q == interval);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SNAP_ARMED;
        else
            state_q <= state_d;
    end

    // counters and mode history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            ivl_q   <= '0;
            burst_q <= '0;
        end else begin
            mode_q  <= mode_fifo;
            ivl_q   <= ivl_d;
            burst_q <= burst_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d      = state_q;
        ivl_d        = ivl_q;
        burst_d      = burst_q;
        wr_req_o     = 1'b0;
        snap_start_o = 1'b0;
        if (clear_o) begin
            state_d = mode_fifo ? ST_FIFO_RUN : ST_SNAP_ARMED;
            ivl_d   = '0;
            burst_d = '0;
        end else begin
            unique case (state_q)
                ST_FIFO_RUN: begin
                    wr_req_o = in_valid;
                end
                ST_SNAP_ARMED: begin
                    if (in_valid)
                        ivl_d = timeout ? '0 : ivl_q + IVL_W'(1);
                    if (timeout) begin
                        wr_req_o     = 1'b1;
                        snap_start_o = 1'b1;
                        if (n_eff != BCW'(1)) begin
                            state_d = ST_SNAP_BURST;
                            burst_d = BCW'(1);
                        end
                    end
                end
                ST_SNAP_BURST: begin
                    if (in_valid) begin
                        ivl_d    = timeout ? '0 : ivl_q + IVL_W'(1);
                        wr_req_o = 1'b1;
                        if (burst_q + BCW'(1) == n_eff) begin
                            state_d = ST_SNAP_ARMED;
                            burst_d = '0;
                        end else begin
                            burst_d = burst_q + BCW'(1);
                        end
                    end
                end
                default: begin
                    state_d = mode_fifo ? ST_FIFO_RUN : ST_SNAP_ARMED;
                end
            endcase
        end
    end

    assign fifo_active_o = (state_q == ST_FIFO_RUN);
endmodule

// File: rtl/dmsb_ptrs.sv
module dmsb_ptrs #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          snap_start,
    input  logic          wr_req,
    input  logic          rd_advance,
    input  logic          fifo_active,
    input  logic [AW-1:0] thresh,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW:0]   depth_o,
    output logic          ready_o,
    output logic          irq_o,
    output logic          overflow_o
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;

    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] depth_q, eff;
    logic          full, acc_wr, acc_rd, ovf_q, irq_q;

    assign eff    = (thresh == '0) ? CW'(1) : {1'b0, thresh};
    assign full   = (depth_q == CW'(DEPTH));
    assign acc_wr = wr_req && !clear && (snap_start || !full);
    assign acc_rd = rd_advance && !clear && !snap_start && (depth_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= '1;
            wr_q    <= '0;
            depth_q <= '0;
            ovf_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else if (clear) begin
            rd_q    <= '1;
            wr_q    <= '0;
            depth_q <= '0;
            ovf_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else if (snap_start) begin
            rd_q    <= '1;
            wr_q    <= AW'(1);
            depth_q <= CW'(1);
            irq_q   <= 1'b0;
        end else begin
            if (acc_wr)
                wr_q <= wr_q + AW'(1);
            if (acc_rd)
                rd_q <= rd_q + AW'(1);
            if (acc_wr && !acc_rd)
                depth_q <= depth_q + CW'(1);
            else if (acc_rd && !acc_wr)
                depth_q <= depth_q - CW'(1);
            if (wr_req && full && fifo_active)
                ovf_q <= 1'b1;
            irq_q <= fifo_active && acc_wr && !acc_rd && (depth_q == eff - CW'(1));
        end
    end

    assign wr_en_o    = acc_wr;
    assign wr_addr_o  = snap_start ? '0 : wr_q;
    assign rd_addr_o  = rd_q + AW'(1);
    assign depth_o    = depth_q;
    assign ready_o    = fifo_active && (depth_q >= eff);
    assign irq_o      = irq_q;
    assign overflow_o = ovf_q;
endmodule

// File: rtl/dual_mode_sample_buf.sv
module dual_mode_sample_buf #(
    parameter int DATA_W = 16,
    parameter int AW     = 3,
    parameter int IVL_W  = 8,
    parameter int BL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_fifo,
    input  logic [AW-1:0]     fifo_thresh,
    input  logic [IVL_W-1:0]  snap_interval,
    input  logic [BL_W-1:0]   snap_count,
    input  logic              ptr_reset,
    input  logic              rd_advance,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [AW:0]       fill_depth,
    output logic              ready,
    output logic              irq,
    output logic              overflow
);
    logic          clear, wr_req, snap_start, fifo_active, wr_en;
    logic [AW-1:0] wr_addr, rd_addr;

    dmsb_ctrl #(.AW(AW), .IVL_W(IVL_W), .BL_W(BL_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_fifo     (mode_fifo),
        .ptr_reset     (ptr_reset),
        .in_valid      (in_valid),
        .interval      (snap_interval),
        .burst_len     (snap_count),
        .clear_o       (clear),
        .wr_req_o      (wr_req),
        .snap_start_o  (snap_start),
        .fifo_active_o (fifo_active)
    );

    dmsb_ptrs #(.AW(AW)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .snap_start  (snap_start),
        .wr_req      (wr_req),
        .rd_advance  (rd_advance),
        .fifo_active (fifo_active),
        .thresh      (fifo_thresh),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .rd_addr_o   (rd_addr),
        .depth_o     (fill_depth),
        .ready_o     (ready),
        .irq_o       (irq),
        .overflow_o  (overflow)
    );

    dmsb_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (in_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/dmsb_chk.sv
module dmsb_chk #(
    parameter int AW = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_fifo,
    input logic        ptr_reset,
    input logic        rd_advance,
    input logic        in_valid,
    input logic [AW:0] fill_depth,
    input logic        ready,
    input logic        irq,
    input logic        overflow
);
    localparam int DEPTH = 1 << AW;

    // R3
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_depth <= (AW+1)'(DEPTH));

    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ptr_reset && $stable(mode_fifo)) |=> overflow);

    // R7
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_reset |=> (fill_depth == '0 && !overflow && !irq));

    // R6
    snap_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_fifo && $stable(mode_fifo)) |-> !ready);

    // R2
    empty_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_depth == '0 && rd_advance && !in_valid && !ptr_reset && $stable(mode_fifo))
        |=> fill_depth == '0);
endmodule

bind dual_mode_sample_buf dmsb_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_fifo  (mode_fifo),
    .ptr_reset  (ptr_reset),
    .rd_advance (rd_advance),
    .in_valid   (in_valid),
    .fill_depth (fill_depth),
    .ready      (ready),
    .irq        (irq),
    .overflow   (overflow)
);

// File: tb/dual_mode_sample_buf_tb.sv
`timescale 1ns/1ps
module dual_mode_sample_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_fifo;
    logic [2:0]  fifo_thresh;
    logic [7:0]  snap_interval;
    logic [3:0]  snap_count;
    logic        ptr_reset, rd_advance, in_valid;
    logic [15:0] in_data;
    logic [15:0] rd_data;
    logic [3:0]  fill_depth;
    logic        ready, irq, overflow;

    int nvec = 0;
    int nerr = 0;
    int mdepth = 0;
    logic [15:0] exp_q [$];

    always #4 clk = ~clk;

    dual_mode_sample_buf u_dut (
        .clk(clk), .rst_n(rst_n), .mode_fifo(mode_fifo), .fifo_thresh(fifo_thresh),
        .snap_interval(snap_interval), .snap_count(snap_count), .ptr_reset(ptr_reset),
        .rd_advance(rd_advance), .in_valid(in_valid), .in_data(in_data),
        .rd_data(rd_data), .fill_depth(fill_depth), .ready(ready), .irq(irq),
        .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // driver: queue-mode write, pushes expected item when it should be kept
    task automatic push(input logic [15:0] d);
        if (mdepth < 8) begin
            exp_q.push_back(d);
            mdepth++;
        end
        in_valid = 1'b1;
        in_data  = d;
        step();
        in_valid = 1'b0;
    endtask

    // monitor: compares the presented entry against the scoreboard, then advances
    task automatic pop_check(input string req);
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(req, rd_data, e);
        mdepth--;
        rd_advance = 1'b1;
        step();
        rd_advance = 1'b0;
    endtask

    // capture-mode sample, no scoreboard
    task automatic sample(input logic [15:0] d, input bit gap);
        in_valid = 1'b1;
        in_data  = d;
        step();
        in_valid = 1'b0;
        if (gap) step();
    endtask

    task automatic adv();
        rd_advance = 1'b1;
        step();
        rd_advance = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_fifo = 1'b0; fifo_thresh = 3'd3; snap_interval = 8'd4;
        snap_count = 4'd3; ptr_reset = 1'b0; rd_advance = 1'b0; in_valid = 1'b0;
        in_data = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 depth", 32'(fill_depth), 0);
        chk("R1 ready", 32'(ready), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 overflow", 32'(overflow), 0);

        // enter queue mode
        mode_fifo = 1'b1;
        step();
        chk("R8 depth after switch", 32'(fill_depth), 0);
        push(16'hA000);
        chk("R1 first entry visible", 32'(rd_data), 32'h A000);
        push(16'hA001);
        chk("R5 no irq below thr", 32'(irq), 0);
        chk("R6 no ready below thr", 32'(ready), 0);
        push(16'hA002);
        chk("R5 irq at thr", 32'(irq), 1);
        chk("R6 ready at thr", 32'(ready), 1);
        chk("R3 depth 3", 32'(fill_depth), 3);
        step();
        chk("R5 irq one cycle", 32'(irq), 0);
        push(16'hA003);
        chk("R5 no irq above thr", 32'(irq), 0);
        pop_check("R2 order");
        pop_check("R2 order");
        chk("R6 ready drops", 32'(ready), 0);
        chk("R2 depth after reads", 32'(fill_depth), 2);
        // R3 simultaneous write and advance
        chk("R3 front", 32'(rd_data), 32'(exp_q[0]));
        void'(exp_q.pop_front());
        exp_q.push_back(16'hA004);
        in_valid = 1'b1; in_data = 16'hA004; rd_advance = 1'b1;
        step();
        in_valid = 1'b0; rd_advance = 1'b0;
        chk("R3 depth unchanged", 32'(fill_depth), 2);
        for (int i = 5; i < 11; i++) push(16'hA000 + 16'(i));
        chk("R3 full", 32'(fill_depth), 8);
        push(16'hA0FF);
        chk("R4 overflow set", 32'(overflow), 1);
        chk("R4 depth held", 32'(fill_depth), 8);
        for (int i = 0; i < 8; i++) pop_check("R4 stored order");
        chk("R4 overflow sticky", 32'(overflow), 1);
        adv();
        chk("R2 empty advance", 32'(fill_depth), 0);
        push(16'hA0C0);
        pop_check("R2 pointer kept on empty advance");

        // R7 reset command
        push(16'hA0D0);
        ptr_reset = 1'b1;
        step();
        ptr_reset = 1'b0;
        exp_q.delete(); mdepth = 0;
        chk("R7 depth", 32'(fill_depth), 0);
        chk("R7 overflow cleared", 32'(overflow), 0);
        fifo_thresh = 3'd0;
        push(16'hB000);
        chk("R5 thr0 acts as 1", 32'(irq), 1);
        chk("R7 entry 0 after reset cmd", 32'(rd_data), 32'h B000);
        push(16'hB001);

        // R8 switch to capture mode clears
        mode_fifo = 1'b0;
        step();
        exp_q.delete(); mdepth = 0;
        chk("R8 depth cleared", 32'(fill_depth), 0);
        chk("R6 no ready in capture", 32'(ready), 0);

        // R9/R10 interval 4, burst 3, gaps between samples
        for (int i = 0; i < 4; i++) sample(16'hC000 + 16'(i), i[0]);
        chk("R9 no capture before timeout", 32'(fill_depth), 0);
        for (int i = 4; i < 8; i++) sample(16'hC000 + 16'(i), i[0]);
        chk("R10 burst depth", 32'(fill_depth), 3);
        chk("R10 burst first", 32'(rd_data), 32'h C004);
        chk("R6 ready low capture", 32'(ready), 0);
        adv();
        chk("R10 burst second", 32'(rd_data), 32'h C005);
        adv();
        chk("R10 burst third", 32'(rd_data), 32'h C006);
        sample(16'hC008, 1'b0);
        chk("R10 no store after burst", 32'(fill_depth), 1);
        sample(16'hC009, 1'b1);
        chk("R9 next timeout", 32'(rd_data), 32'h C009);
        chk("R10 restart depth", 32'(fill_depth), 1);

        // R11 burst length 0 acts as 1
        ptr_reset = 1'b1; step(); ptr_reset = 1'b0;
        snap_count = 4'd0; snap_interval = 8'd1;
        for (int i = 0; i < 2; i++) sample(16'hD000 + 16'(i), 1'b0);
        chk("R11 len0 depth", 32'(fill_depth), 1);
        chk("R11 len0 data", 32'(rd_data), 32'h D001);
        for (int i = 2; i < 4; i++) sample(16'hD000 + 16'(i), 1'b0);
        chk("R11 len0 next", 32'(rd_data), 32'h D003);

        // R10 timeouts inside a burst are ignored
        ptr_reset = 1'b1; step(); ptr_reset = 1'b0;
        snap_count = 4'd5;
        for (int i = 0; i < 6; i++) sample(16'hF000 + 16'(i), 1'b0);
        chk("R10 burst of 5", 32'(fill_depth), 5);
        chk("R10 burst head", 32'(rd_data), 32'h F001);
        sample(16'hF006, 1'b0);
        chk("R10 idle after burst", 32'(fill_depth), 5);
        sample(16'hF007, 1'b0);
        chk("R10 new burst", 32'(rd_data), 32'h F007);

        // R11 clamp above 8
        ptr_reset = 1'b1; step(); ptr_reset = 1'b0;
        snap_count = 4'd12; snap_interval = 8'd9;
        for (int i = 0; i < 17; i++) sample(16'hE000 + 16'(i), 1'b0);
        chk("R11 clamp depth", 32'(fill_depth), 8);
        chk("R11 clamp head", 32'(rd_data), 32'h E009);
        sample(16'hE011, 1'b0);
        chk("R11 clamp stops", 32'(fill_depth), 8);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule